// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder, K=7 Rate 1/2

This block recovers information bits from a stream of hard-decision coded bit pairs. The pairs were produced by a rate-1/2 convolutional encoder with constraint length 7 and generator polynomials 171 and 133 (octal). Each accepted symbol is first turned into four branch metrics. A 64-state add-compare-select array then updates the unsigned path metrics and emits one survivor decision per state. The decisions are kept in a circular survivor store. A traceback walks this store from the current best state and releases one information bit per symbol, a fixed number of symbols behind the input.

The source marks the first symbol of a frame so that the metrics restart in the all-zero encoder state. It marks the last symbol so that the decoder drains the bits still held in the traceback window, oldest first, one per cycle. After a last symbol the source stays idle until the drain has finished. That is at most depth+1 cycles. Idle cycles inside a frame are allowed.

Top module: `hd_viterbi_k7`

## Requirements
- R1: The encoder model shifts each new bit into the most significant position of a 7-bit register: new bit at bit 6, the six previous bits below it, oldest at bit 0. `in_sym[1]` carries the parity of that register masked by 171 octal, and `in_sym[0]` carries the parity masked by 133 octal. For an error-free frame, the output bit sequence equals the encoder input sequence.
- R2: In a frame of more than 34 symbols, a symbol accepted in cycle c that brings the frame count to n > 34 causes `out_valid` in cycle c+2, carrying information bit n-35 (counting from 0). No other cycle carries `out_valid` except the drain.
- R3: After the last symbol of a frame of N symbols, the final min(N,34) bits are emitted in order on consecutive cycles. For N > 34 they follow the normal output of the last symbol immediately.
- R4: Single coded-bit errors spaced 16 symbols apart are fully corrected. None falls within the final 40 symbols.
- R5: A symbol with `in_first` set restarts the path metrics: state 0 gets metric 0 and every other state a large initial value. Decoding of the new frame does not depend on the previous frame.
- R6: The path metrics are 7 bits wide. When the smallest metric has its MSB set, half the metric range is subtracted from every metric. This keeps long frames with many corrected errors decoded correctly.
- R7: A frame of N ≤ 34 symbols produces no output until its last symbol. If the last symbol is accepted in cycle c, the N bits then appear in cycles c+2 to c+N+1.
- R8: After reset `out_valid` is low until a frame produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A coded symbol is present this cycle |
| in_first | input | 1 | Symbol is the first of a frame |
| in_last | input | 1 | Symbol is the last of a frame |
| in_sym | input | 2 | Hard-decision pair; bit 1 from generator 171, bit 0 from generator 133 |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded information bit |

## Verification
The bench uses the default parameters: constraint length 7, traceback depth 34, 7-bit metrics and an initial metric of 24. The narrow metric width makes a frame of about 2200 symbols with more than 130 corrected errors wrap the metric range more than once, so normalization is exercised. The depth of 34 places the frame lengths 20, 34 and 35 on either side of the point where normal output begins.

// File: rtl/hdv_pkg.sv
package hdv_pkg;

   // Parity of the bits of v selected by mask
   function automatic int tap_parity(input int v, input int mask);
      int p;
      p = 0;
      for (int i = 0; i < 31; i++) p = p ^ ((v & mask) >> i & 1);
      return p;
   endfunction

   // Two-bit code word {gen A, gen B} for a full shift register value
   function automatic int pair_code(input int sr, input int gen_a, input int gen_b);
      return 2 * tap_parity(sr, gen_a) + tap_parity(sr, gen_b);
   endfunction

endpackage

// File: rtl/hdv_bmu.sv
module hdv_bmu #(
   parameter int BMW = 2
) (
   input  logic [1:0]           sym_i,
   output logic [3:0][BMW-1:0]  bm_o
);
   // One Hamming distance per possible code pair
   for (genvar c = 0; c < 4; c++) begin : g_code
      localparam logic [1:0] CODE = 2'(c);
      assign bm_o[c] = BMW'(sym_i[1] ^ CODE[1]) + BMW'(sym_i[0] ^ CODE[0]);
   end
endmodule

// File: rtl/hdv_acs.sv
module hdv_acs #(
   parameter int K     = 7,
   parameter int W     = 7,
   parameter int INIT  = 24,
   parameter int GEN_A = 'o171,
   parameter int GEN_B = 'o133
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sym_valid,
   input  logic                 frame_start,
   input  logic [3:0][1:0]      bm_i,
   output logic [(1<<(K-1))-1:0] dec_o,
   output logic [K-2:0]         best_state_o,
   output logic [W-1:0]         best_pm_o
);
   localparam int NS   = 1 << (K-1);
   localparam int SW   = K - 1;
   localparam int HALF = 1 << (W-1);

   logic [W-1:0] pm_q  [NS];
   logic [W-1:0] nxt   [NS];
   logic [W-1:0] min_v, max_v;
   logic [SW-1:0] min_i;
   logic norm;

   always_comb begin
      min_v = pm_q[0];
      max_v = pm_q[0];
      min_i = '0;
      for (int s = 1; s < NS; s++) begin
         if (pm_q[s] < min_v) begin
            min_v = pm_q[s];
            min_i = SW'(s);
         end
         if (pm_q[s] > max_v) max_v = pm_q[s];
      end
   end

   assign norm         = !frame_start && min_v[W-1];
   assign best_state_o = min_i;
   assign best_pm_o    = min_v;

   for (genvar j = 0; j < NS; j++) begin : g_state
      localparam int U  = j / (NS/2);
      localparam int P0 = (j % (NS/2)) * 2;
      localparam int P1 = P0 + 1;
      localparam int C0 = hdv_pkg::pair_code(U*NS + P0, GEN_A, GEN_B);
      localparam int C1 = hdv_pkg::pair_code(U*NS + P1, GEN_A, GEN_B);
      logic [W-1:0] s0, s1, c0, c1;
      logic pick;
      always_comb begin
         s0   = frame_start ? ((P0 == 0) ? '0 : W'(INIT)) : pm_q[P0];
         s1   = frame_start ? W'(INIT) : pm_q[P1];
         c0   = s0 + W'(bm_i[C0]);
         c1   = s1 + W'(bm_i[C1]);
         pick = c1 < c0;
      end
      assign nxt[j]   = (pick ? c1 : c0) - (norm ? W'(HALF) : '0);
      assign dec_o[j] = pick;
   end

   always_ff @(posedge clk) begin
      for (int s = 0; s < NS; s++) begin
         if (!rst_n)         pm_q[s] <= (s == 0) ? '0 : W'(INIT);
         else if (sym_valid) pm_q[s] <= nxt[s];
      end
   end

   // R6
   pm_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (max_v - min_v) < W'(1 << (W-2)));
   // R6
   norm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !frame_start && min_v[W-1]) |=> !min_v[W-1]);
   // R5
   start_metric_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && frame_start) |=> (min_v <= W'(2)));
endmodule

// File: rtl/hdv_surv.sv
module hdv_surv #(
   parameter int K  = 7,
   parameter int TB = 34
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [(1<<(K-1))-1:0]      dec_i,
   input  logic [K-2:0]               start_i,
   input  logic [$clog2(TB+1)-1:0]    depth_i,
   output logic                       bit_o
);
   localparam int NS   = 1 << (K-1);
   localparam int SW   = K - 1;
   localparam int PW   = $clog2(TB);
   localparam int SELW = $clog2(TB+1);

   logic [NS-1:0] mem [TB];
   logic [PW-1:0] head_q, head_nx;

   assign head_nx = (head_q == PW'(TB-1)) ? '0 : head_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)     head_q <= PW'(TB-1);
      else if (wr_en) head_q <= head_nx;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[head_nx] <= dec_i;
   end

   // Walk back from the start state; pick the bit at the requested depth
   logic [SW-1:0] st;
   int col;
   always_comb begin
      st    = start_i;
      bit_o = start_i[SW-1];
      col   = 0;
      for (int d = 0; d < TB; d++) begin
         col = (int'(head_q) + TB - d) % TB;
         st  = {st[SW-2:0], mem[col][st]};
         if (depth_i == SELW'(d+1)) bit_o = st[SW-1];
      end
   end

   // R2
   head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(head_q));
endmodule

// File: rtl/hd_viterbi_k7.sv
module hd_viterbi_k7 #(
   parameter int K     = 7,
   parameter int TB    = 34,
   parameter int W     = 7,
   parameter int INIT  = 24,
   parameter int GEN_A = 'o171,
   parameter int GEN_B = 'o133
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_first,
   input  logic       in_last,
   input  logic [1:0] in_sym,
   output logic       out_valid,
   output logic       out_bit
);
   localparam int NS   = 1 << (K-1);
   localparam int CW   = $clog2(TB+2);
   localparam int SELW = $clog2(TB+1);

   initial begin
      assert (K >= 3)                  else $error("K too small");
      assert (TB >= 2)                 else $error("TB too small");
      assert (INIT > 2*(K-1))          else $error("INIT too small to force start state");
      assert (INIT < (1 << (W-2)))     else $error("INIT too large for metric width");
   end

   logic [3:0][1:0] bm;
   logic [NS-1:0]   dec;
   logic [K-2:0]    best_state;
   logic [W-1:0]    best_pm;
   logic [CW-1:0]   cnt_q, cnt_nx;
   logic            go_q;
   logic [SELW-1:0] rem_q, depth;
   logic            tb_bit;

   hdv_bmu #(.BMW(2)) u_bmu (.sym_i(in_sym), .bm_o(bm));

   hdv_acs #(.K(K), .W(W), .INIT(INIT), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_acs (
      .clk(clk), .rst_n(rst_n), .sym_valid(in_valid), .frame_start(in_first),
      .bm_i(bm), .dec_o(dec), .best_state_o(best_state), .best_pm_o(best_pm));

   hdv_surv #(.K(K), .TB(TB)) u_surv (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .dec_i(dec),
      .start_i(best_state), .depth_i(depth), .bit_o(tb_bit));

   assign cnt_nx = in_first ? CW'(1) : ((cnt_q == CW'(TB+1)) ? cnt_q : cnt_q + 1'b1);
   assign depth  = go_q ? SELW'(TB) : rem_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         go_q      <= 1'b0;
         rem_q     <= '0;
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= go_q || (rem_q != '0);
         out_bit   <= tb_bit;
         go_q      <= in_valid && (cnt_nx > CW'(TB));
         if (in_valid) cnt_q <= cnt_nx;
         if (in_valid && in_last)
            rem_q <= (cnt_nx > CW'(TB)) ? SELW'(TB) : SELW'(cnt_nx);
         else if (!go_q && rem_q != '0)
            rem_q <= rem_q - 1'b1;
      end
   end

   // R2
   go_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_first && cnt_q >= CW'(TB)) |=> go_q);
   // R2
   emit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |=> out_valid);
   // R3
   drain_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> (rem_q != '0));
   // R3
   drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_q && rem_q != '0 && !in_valid) |=> (rem_q == $past(rem_q) - 1'b1));
   // R7
   count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first) |=> (cnt_q == CW'(1)));
   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

// File: tb/hd_viterbi_k7_tb.sv
module hd_viterbi_k7_tb;
   localparam int TBD = 34;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [1:0] in_sym = 2'b00;
   logic out_valid, out_bit;

   hd_viterbi_k7 u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_sym(in_sym), .out_valid(out_valid), .out_bit(out_bit));

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;
   int    qc[$];
   bit    qb[$];
   string qt[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
      end
   endtask

   // Reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (qc.size() > 0 && qc[0] == cyc) begin
            check(out_valid === 1'b1, qt[0], "out_valid", int'(out_valid), 1);
            check(out_bit === qb[0], qt[0], "out_bit", int'(out_bit), int'(qb[0]));
            void'(qc.pop_front());
            void'(qb.pop_front());
            void'(qt.pop_front());
         end else if (out_valid !== 1'b0) begin
            check(1'b0, "R2", "unexpected out_valid", int'(out_valid), 0);
         end
      end
   end

   // pat: 0 random, 1 all ones; espace: error spacing in symbols (0 none)
   task automatic send_frame(input int n, input int pat, input int espace,
                             input bit gaps, input string tag);
      bit data[$];
      logic [5:0] st;
      logic [6:0] sr;
      logic [1:0] sym;
      int base, rem;
      st = '0;
      for (int k = 0; k < n; k++) data.push_back(pat == 1 ? 1'b1 : 1'($urandom % 2));
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (gaps && ($urandom % 4 == 0)) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
         sr  = {data[k], st};
         sym = {^(sr & 7'o171), ^(sr & 7'o133)};
         st  = sr[6:1];
         if (espace > 0 && (k % espace) == espace/2 && k + 40 < n)
            sym = sym ^ (((k / espace) % 2) ? 2'b01 : 2'b10);
         in_valid = 1'b1;
         in_first = (k == 0);
         in_last  = (k == n-1);
         in_sym   = sym;
         if (k + 1 > TBD) begin
            qc.push_back(cyc + 2); qb.push_back(data[k - TBD]); qt.push_back(tag);
         end
         if (k == n-1) begin
            base = cyc + 2 + ((n > TBD) ? 1 : 0);
            rem  = (n > TBD) ? TBD : n;
            for (int j = 0; j < rem; j++) begin
               qc.push_back(base + j); qb.push_back(data[n - rem + j]);
               qt.push_back(n <= TBD ? "R7" : "R3");
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      repeat (TBD + 6) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog expired: actual %0d expected %0d", qc.size(), 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R8: quiet after reset
      repeat (3) begin
         @(negedge clk);
         check(out_valid === 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
      end
      send_frame(200, 0, 0, 1'b0, "R1");     // R1 clean random data
      send_frame(120, 1, 0, 1'b0, "R5");     // R5 new frame after a different one
      send_frame(300, 0, 0, 1'b1, "R2");     // R2 latency with idle gaps
      send_frame(400, 0, 16, 1'b1, "R4");    // R4 isolated errors
      send_frame(2200, 0, 16, 1'b0, "R6");   // R6 metric normalization
      send_frame(20, 0, 0, 1'b0, "R7");      // R7 short frame
      send_frame(34, 0, 0, 1'b0, "R3");      // R3 frame equal to depth
      send_frame(35, 0, 0, 1'b0, "R3");      // R3 one beyond depth
      send_frame(150, 0, 16, 1'b0, "R5");    // R5 restart after an errored frame
      check(qc.size() == 0, "R3", "outputs outstanding", qc.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule